// File: doc/BRIEF.md
# Parallel Transposition Sorter

This block sorts a batch of unsigned words held in a chain of registers, one register per word. A compare-and-exchange cell sits between every pair of adjacent registers. During a sort, every other cell fires on each clock cycle and the two sets take turns. After as many cycles as there are words, the chain is in ascending order. The default build holds 48 words of 8 bits each. Both counts are parameters.

Words enter one per cycle at the top of the chain while the block is idle. Every load moves the whole chain one place toward register 0. A start request launches the sort. When the sort ends, the block raises a one-cycle done pulse and then drains the chain through register 0, smallest word first. Zeros fill the chain from the top as it drains. No wide output multiplexer is needed because the chain itself shifts the data out.

Top module: `oet_sorter`

## Requirements
- R1: After reset, busy, done and out_valid are low and every register in the chain holds zero. A start request issued right after reset therefore drains N zero words.
- R2: While idle, start is low and in_valid is high, in_data is written into register N-1 and every register k takes the old value of register k+1. The oldest word in register 0 is lost, so the chain always holds the last N words loaded.
- R3: A start request while idle makes busy high from the next cycle. If start and in_valid are high in the same cycle, start wins and that in_data word is not loaded.
- R4: The sort lasts exactly N cycles. On the 1st, 3rd, 5th, ... cycle, the pairs (0,1), (2,3), ... exchange if the lower register holds the larger value. On the other cycles, the pairs (1,2), (3,4), ... do the same.
- R5: done is high for exactly one cycle, the first cycle after the last sort cycle, and out_valid is high in that same cycle.
- R6: The drain lasts exactly N cycles with out_valid high. out_data presents the words in ascending order, smallest first. busy stays high through the sort and the drain and falls in the cycle after the last word.
- R7: While busy, in_valid and start have no effect. The words drained are those loaded before the start request.
- R8: Sorting keeps the multiset of words, duplicates included.
- R9: A drain leaves the chain filled with zeros. If fewer than N words are loaded before the next start, zeros make up the rest and drain first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Load in_data into the chain this cycle (idle only) |
| in_data | input | W | Word to load |
| start | input | 1 | Begin a sort (idle only) |
| busy | output | 1 | High during the sort and the drain |
| done | output | 1 | One-cycle pulse when the sort has finished |
| out_valid | output | 1 | out_data carries a sorted word |
| out_data | output | W | Sorted word, ascending order |

## Verification
The hardest case to reach from the ports is a sort that needs every one of the N phases. In that case the minimum word starts in the top register and the maximum in register 0, so a wrong phase count or a wrong starting pair parity would leave one word out of place. The stimulus reaches it by loading a strictly descending batch. It also loads batches with heavy duplication, where equal neighbours must not disturb the count of each value. Separate sequences cover the ignored inputs. In one, a start request coincides with a load. In another, loads and start requests are driven throughout a sort. A third loads more than N words so that the oldest fall out of register 0.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SORT  = 2'd1,
        ST_DRAIN = 2'd2
    } sort_state_e;

    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_LOAD   = 3'd1,
        OP_SORT_A = 3'd2,
        OP_SORT_B = 3'd3,
        OP_DRAIN  = 3'd4
    } chain_op_e;

endpackage

// File: rtl/cas_cell.sv
module cas_cell #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic swap;

    assign swap = (a > b);
    assign lo   = swap ? b : a;
    assign hi   = swap ? a : b;
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
    import sorter_pkg::*;
#(
    parameter int N = 48
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      start,
    output chain_op_e op,
    output logic      busy,
    output logic      done,
    output logic      out_valid
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        sort_state_e   state;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        op          = OP_HOLD;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctrl_d.state = ST_SORT;
                    ctrl_d.cnt   = '0;
                end else if (in_valid) begin
                    op = OP_LOAD;
                end
            end
            ST_SORT: begin
                op = ctrl_q.cnt[0] ? OP_SORT_B : OP_SORT_A;
                if (ctrl_q.cnt == LAST) begin
                    ctrl_d.state = ST_DRAIN;
                    ctrl_d.cnt   = '0;
                    ctrl_d.done  = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            ST_DRAIN: begin
                op = OP_DRAIN;
                if (ctrl_q.cnt == LAST) begin
                    ctrl_d.state = ST_IDLE;
                    ctrl_d.cnt   = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            default: begin
                ctrl_d.state = ST_IDLE;
                ctrl_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, cnt: '0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy      = (ctrl_q.state != ST_IDLE);
    assign done      = ctrl_q.done;
    assign out_valid = (ctrl_q.state == ST_DRAIN);

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R3
    AST_IDLE_NO_OP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (op != OP_LOAD)); // R7
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.cnt <= LAST); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid); // R5
    AST_VALID_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy); // R6
endmodule

// File: rtl/sort_chain.sv
module sort_chain
    import sorter_pkg::*;
#(
    parameter int N = 48,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  chain_op_e    op,
    input  logic [W-1:0] in_data,
    output logic [W-1:0] out_data
);
    localparam int NP = N - 1;

    typedef struct packed {
        logic [N-1:0][W-1:0] regs;
    } chain_t;

    chain_t chain_d, chain_q;

    logic [W-1:0] pair_lo [NP];
    logic [W-1:0] pair_hi [NP];

    for (genvar g = 0; g < NP; g++) begin : g_pair
        cas_cell #(.W(W)) u_cas (
            .a (chain_q.regs[g]),
            .b (chain_q.regs[g+1]),
            .lo(pair_lo[g]),
            .hi(pair_hi[g])
        );
    end

    always_comb begin
        chain_d = chain_q;
        unique case (op)
            OP_LOAD, OP_DRAIN: begin
                for (int i = 0; i < NP; i++) begin
                    chain_d.regs[i] = chain_q.regs[i+1];
                end
                chain_d.regs[N-1] = (op == OP_LOAD) ? in_data : '0;
            end
            OP_SORT_A: begin
                for (int i = 0; i < NP; i++) begin
                    if ((i % 2) == 0) begin
                        chain_d.regs[i]   = pair_lo[i];
                        chain_d.regs[i+1] = pair_hi[i];
                    end
                end
            end
            OP_SORT_B: begin
                for (int i = 0; i < NP; i++) begin
                    if ((i % 2) == 1) begin
                        chain_d.regs[i]   = pair_lo[i];
                        chain_d.regs[i+1] = pair_hi[i];
                    end
                end
            end
            default: chain_d = chain_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign out_data = chain_q.regs[0];

    AST_LOAD_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (chain_q.regs[N-1] == $past(in_data))); // R2
    AST_DRAIN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DRAIN) |=> (chain_q.regs[0] == $past(chain_q.regs[1]))); // R6
    AST_DRAIN_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DRAIN) |=> (chain_q.regs[N-1] == '0)); // R9
    AST_PAIR_A_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SORT_A) |=> (chain_q.regs[0] <= chain_q.regs[1])); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(chain_q.regs)); // R7
endmodule

// File: rtl/oet_sorter.sv
module oet_sorter
    import sorter_pkg::*;
#(
    parameter int N = 48,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         start,
    output logic         busy,
    output logic         done,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    chain_op_e op;

    sort_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .start    (start),
        .op       (op),
        .busy     (busy),
        .done     (done),
        .out_valid(out_valid)
    );

    sort_chain #(.N(N), .W(W)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .in_data (in_data),
        .out_data(out_data)
    );

    AST_DRAIN_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !done) |-> (out_data >= $past(out_data))); // R6
endmodule

// File: tb/oet_sorter_test.sv
`timescale 1ns/1ps
module oet_sorter_test;
    localparam int N = 48;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         start = 1'b0;
    logic         busy, done, out_valid;
    logic [W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    oet_sorter #(.N(N), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .start(start), .busy(busy), .done(done), .out_valid(out_valid),
        .out_data(out_data)
    );

    // behavioural reference: 0 idle, 1 sorting, 2 draining
    int         mst = 0;
    int         mcnt = 0;
    bit         mdone = 0;
    int         mq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mcnt = 0; mdone = 0;
            mq.delete();
            for (int i = 0; i < N; i++) mq.push_back(0);
        end else begin
            case (mst)
                0: begin
                    mdone = 0;
                    if (start) begin
                        mst = 1; mcnt = 0;
                    end else if (in_valid) begin
                        void'(mq.pop_front());
                        mq.push_back(int'(in_data));
                    end
                end
                1: begin
                    if (mcnt == N - 1) begin
                        mst = 2; mcnt = 0; mdone = 1;
                        mq.sort();
                    end else mcnt++;
                end
                default: begin
                    mdone = 0;
                    void'(mq.pop_front());
                    mq.push_back(0);
                    if (mcnt == N - 1) begin
                        mst = 0; mcnt = 0;
                    end else mcnt++;
                end
            endcase
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R4/R6", "busy", int'(busy), int'(mst != 0));
            chk("R5", "done", int'(done), int'(mdone));
            chk("R6", "out_valid", int'(out_valid), int'(mst == 2));
            if (mst == 2 && out_valid) chk("R8", "out_data", int'(out_data), mq[0]);
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive(input bit iv, input int d, input bit st);
        in_valid = iv;
        in_data  = W'(d);
        start    = st;
        @(negedge clk);
    endtask

    task automatic idle_wait();
        while (busy) drive(0, 0, 0);
    endtask

    task automatic run_sort();
        drive(0, 0, 1);
        idle_wait();
        drive(0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        drive(0, 0, 0);
        chk("R1", "busy after reset", int'(busy), 0);
        // R1: start straight after reset drains zeros
        run_sort();

        // random batch (R2, R8)
        for (int i = 0; i < N; i++) drive(1, int'($urandom_range(0, 255)), 0);
        run_sort();

        // ascending batch
        for (int i = 0; i < N; i++) drive(1, i * 5, 0);
        run_sort();

        // descending batch needs every phase (R4); loads and starts during busy are ignored (R7)
        for (int i = 0; i < N; i++) drive(1, 255 - i * 5, 0);
        drive(0, 0, 1);
        chk("R3", "busy after start", int'(busy), 1);
        for (int i = 0; i < 2 * N - 2; i++) drive(1, 77, (i % 3) == 0);
        idle_wait();
        drive(0, 0, 0);

        // duplicate-heavy batch (R8)
        for (int i = 0; i < N; i++) drive(1, (i % 3 == 0) ? 200 : ((i % 2 == 0) ? 3 : 255), 0);
        run_sort();

        // start wins over a simultaneous load (R3)
        for (int i = 0; i < N; i++) drive(1, 10 + i, 0);
        drive(1, 1, 1);
        idle_wait();
        drive(0, 0, 0);

        // partial load after a drain: zeros make up the rest (R9)
        for (int i = 0; i < 5; i++) drive(1, 90 - i, 0);
        run_sort();

        // overload: only the last N words remain (R2)
        for (int i = 0; i < N + 12; i++) drive(1, (i < 12) ? 0 : 100 + i, 0);
        run_sort();

        repeat (3) drive(0, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule